// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block drives a serial test bit stream on `tdata`, advancing one bit on each clock where `bit_en` is high. The bits come from a shift register whose active length N is set at run time by `len_sel` (N = `len_sel` + 1, from 1 to 32 stages). The output is always taken from the top active stage, N-1.

The block has two modes. In repetitive mode, the top stage is fed straight back into stage 0, so a loaded word circulates unchanged. In pseudorandom mode, the feedback is the XOR of the top stage and a second stage picked by `tap_sel`. Two options act on the output only. The first forces a 1 whenever the next 14 bits due out are all zero, which is meant for the quasi-random signal pattern. The second inverts every output bit.

A load copies the 32-bit `seed` word into the register. It is triggered by a rising edge of the OR of `load_reg` and `load_pin`. The strobe must fall again before another load can happen.

Top module: `test_pattern_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every register stage and the load-edge history; after reset, with `tx_inv`=0 and `zsup_en`=0, `tdata` is 0.
- R2: With `prbs_mode`=0 (repetitive), stage N-1 is shifted back into stage 0 unchanged. After a load, `tdata` shows seed bits N-1, N-2, … 0 in that order and then repeats with period N.
- R3: The active length is N = `len_sel`+1, so 1 to 32 stages. `tdata` is taken from stage N-1. Each shift moves stage i into stage i+1.
- R4: With `prbs_mode`=1, the feedback into stage 0 is stage N-1 XOR stage `tap_sel`. With `len_sel`=6 and `tap_sel`=5, a nonzero seed gives a sequence of period 127 that contains 64 ones.
- R5: A load happens only on a 0-to-1 change of (`load_reg` OR `load_pin`). Seed bit i goes into stage i. Holding the strobe high, or raising the second source while the first is already high, does not load again.
- R6: In pseudorandom mode, if seed bits N-1..0 are all zero, the load fills every stage with 1 instead.
- R7: With `zsup_en`=1, `tdata` is forced to 1 whenever stages N-1 down to N-14 are all 0 (only the stages that exist when N<14). The register contents are not changed by this.
- R8: With `tx_inv`=1, every bit on `tdata` is the inverse of the bit it would show with `tx_inv`=0.
- R9: While `bit_en` is 0 and no load edge occurs, the register holds and `tdata` stays fixed.
- R10: A load edge takes effect on the next clock whether or not `bit_en` is high, and it takes priority over a shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable; the register shifts once per enabled cycle |
| len_sel | input | 5 | Active length minus one |
| tap_sel | input | 5 | Stage index of the second feedback tap |
| prbs_mode | input | 1 | 0 = repetitive, 1 = pseudorandom |
| zsup_en | input | 1 | Zero-suppression enable |
| tx_inv | input | 1 | Output inversion enable |
| seed | input | 32 | Pattern/seed word, bit i goes to stage i |
| load_reg | input | 1 | Load strobe from a control register bit |
| load_pin | input | 1 | Load strobe from a pin |
| tdata | output | 1 | Serial test data |

## Verification
The bench goes after the length extremes. A design that took its output from a fixed stage, or that reached the wrong stage, would break the single-stage and 32-stage loops. It checks the load edge detection with a held strobe and with handovers between the two strobe sources; a level-sensitive load would freeze the pattern. It loads an all-zero seed in pseudorandom mode, which without the guard would lock the output at 0. It also counts forced ones in a 20-bit pattern that has a long zero run: a look-ahead window that is off by one changes the count from 13 zeros per period.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int TPG_WIDTH = 32;
    localparam int TPG_ZSPAN = 14;

    typedef enum logic {
        MODE_REPEAT = 1'b0,
        MODE_PRBS   = 1'b1
    } tpg_mode_e;
endpackage

// File: rtl/tpg_stage_pick.sv
// Selects the output stage (N-1) and the programmable tap stage.
module tpg_stage_pick #(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic [W-1:0]  sr,
    input  logic [LW-1:0] head_idx,
    input  logic [LW-1:0] tap_idx,
    output logic          head_bit,
    output logic          tap_bit
);
    assign head_bit = sr[head_idx];
    assign tap_bit  = sr[tap_idx];
endmodule

// File: rtl/tpg_zero_look.sv
// Flags when the next SPAN bits due at the output are all zero.
module tpg_zero_look #(
    parameter int W    = 32,
    parameter int LW   = $clog2(W),
    parameter int SPAN = 14
) (
    input  logic [W-1:0]  sr,
    input  logic [LW-1:0] head_idx,
    output logic          run_zero
);
    logic [SPAN-1:0] slot_clear;

    for (genvar k = 0; k < SPAN; k++) begin : g_slot
        logic [LW-1:0] pos;
        assign pos           = head_idx - LW'(k);
        assign slot_clear[k] = (LW'(k) > head_idx) | ~sr[pos];
    end

    assign run_zero = &slot_clear;
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int W    = TPG_WIDTH,
    parameter int SPAN = TPG_ZSPAN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic [$clog2(W)-1:0] len_sel,
    input  logic [$clog2(W)-1:0] tap_sel,
    input  logic                 prbs_mode,
    input  logic                 zsup_en,
    input  logic                 tx_inv,
    input  logic [W-1:0]         seed,
    input  logic                 load_reg,
    input  logic                 load_pin,
    output logic                 tdata
);
    localparam int LW = $clog2(W);

    typedef struct packed {
        logic [W-1:0] sr;
        logic         load_prev;
    } state_t;

    state_t    st_d, st_q;
    tpg_mode_e mode;
    logic      head_bit, tap_bit, run_zero;
    logic      load_now, load_rise, seed_zero, fb_bit;
    logic [W-1:0] len_mask;

    assign mode = tpg_mode_e'(prbs_mode);

    tpg_stage_pick #(.W(W), .LW(LW)) u_pick (
        .sr       (st_q.sr),
        .head_idx (len_sel),
        .tap_idx  (tap_sel),
        .head_bit (head_bit),
        .tap_bit  (tap_bit)
    );

    tpg_zero_look #(.W(W), .LW(LW), .SPAN(SPAN)) u_look (
        .sr       (st_q.sr),
        .head_idx (len_sel),
        .run_zero (run_zero)
    );

    always_comb begin
        load_now  = load_reg | load_pin;
        load_rise = load_now & ~st_q.load_prev;
        len_mask  = {W{1'b1}} >> (LW'(W - 1) - len_sel);
        seed_zero = ((seed & len_mask) == '0);
        fb_bit    = head_bit ^ ((mode == MODE_PRBS) & tap_bit);

        st_d           = st_q;
        st_d.load_prev = load_now;
        if (load_rise) begin
            st_d.sr = ((mode == MODE_PRBS) && seed_zero) ? {W{1'b1}} : seed;
        end else if (bit_en) begin
            st_d.sr = {st_q.sr[W-2:0], fb_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tdata = ((zsup_en & run_zero) | head_bit) ^ tx_inv;

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && !load_rise) |=> $stable(st_q.sr));

    // R2
    repeat_recirc_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !load_rise && mode == MODE_REPEAT) |=> (st_q.sr[0] == $past(head_bit)));

    // R4
    prbs_feedback_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !load_rise && mode == MODE_PRBS)
        |=> (st_q.sr[0] == ($past(head_bit) ^ $past(tap_bit))));

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (load_rise && !(mode == MODE_PRBS && seed_zero)) |=> (st_q.sr == $past(seed)));

    // R6
    lockup_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (load_rise && mode == MODE_PRBS && seed_zero) |=> (&st_q.sr));

    // R7
    zero_force_chk: assert property (@(posedge clk) disable iff (rst)
        (zsup_en && run_zero) |-> (tdata != tx_inv));
endmodule

// File: tb/test_pattern_gen_bench.sv
`timescale 1ns/1ps
module test_pattern_gen_bench;
    logic        clk = 1'b0;
    logic        rst, bit_en, prbs_mode, zsup_en, tx_inv, load_reg, load_pin;
    logic [4:0]  len_sel, tap_sel;
    logic [31:0] seed;
    logic        tdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit m [32];
    bit mprev;

    always #2 clk = ~clk;

    test_pattern_gen u_test_pattern_gen (
        .clk(clk), .rst(rst), .bit_en(bit_en), .len_sel(len_sel), .tap_sel(tap_sel),
        .prbs_mode(prbs_mode), .zsup_en(zsup_en), .tx_inv(tx_inv), .seed(seed),
        .load_reg(load_reg), .load_pin(load_pin), .tdata(tdata)
    );

    function automatic bit model_out();
        int n = int'(len_sel) + 1;
        bit zero = 1;
        for (int k = 0; k < 14 && k < n; k++) if (m[n-1-k]) zero = 0;
        return ((zsup_en && zero) ? 1'b1 : m[n-1]) ^ tx_inv;
    endfunction

    task automatic model_step();
        int  n = int'(len_sel) + 1;
        bit  lnow = load_reg | load_pin;
        bit  fb;
        bit  allz = 1;
        if (rst) begin
            foreach (m[i]) m[i] = 0;
            mprev = 0;
            return;
        end
        if (lnow && !mprev) begin
            for (int i = 0; i < n; i++) if (seed[i]) allz = 0;
            foreach (m[i]) m[i] = (prbs_mode && allz) ? 1'b1 : seed[i];
        end else if (bit_en) begin
            fb = m[n-1] ^ (prbs_mode & m[tap_sel]);
            for (int i = 31; i > 0; i--) m[i] = m[i-1];
            m[0] = fb;
        end
        mprev = lnow;
    endtask

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: tdata=%0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic tick(string tag);
        #1;
        check(tag, tdata, model_out());
        model_step();
        @(negedge clk);
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ones;
        int zeros;
        rst = 1; bit_en = 0; prbs_mode = 0; zsup_en = 0; tx_inv = 0;
        load_reg = 0; load_pin = 0; len_sel = 0; tap_sel = 0; seed = '0;
        foreach (m[i]) m[i] = 0;
        mprev = 0;
        repeat (2) @(negedge clk);
        tick("R1");
        rst = 0;
        tick("R1");

        // R2: repetitive pattern, N=8
        len_sel = 7; seed = 32'h0000_00B4; bit_en = 1;
        load_reg = 1; tick("R5");
        load_reg = 0; run(24, "R2");

        // R3: single stage and full length
        len_sel = 0; seed = 32'h1; load_pin = 1; tick("R3");
        load_pin = 0; run(5, "R3");
        len_sel = 31; seed = 32'h8000_0001; load_pin = 1; tick("R3");
        load_pin = 0; run(40, "R3");

        // R4: 7-stage pseudorandom, tap at stage 5
        prbs_mode = 1; len_sel = 6; tap_sel = 5; seed = 32'h7F;
        load_reg = 1; tick("R4");
        load_reg = 0;
        ones = 0;
        for (int i = 0; i < 127; i++) begin
            #1;
            if (tdata === 1'b1) ones++;
            check("R4", tdata, model_out());
            model_step();
            @(negedge clk);
        end
        check("R4 ones per period", (ones == 64), 1'b1);
        if (ones != 64) $display("FAIL R4: ones=%0d expected 64", ones);
        run(130, "R4");

        // R6: all-zero active seed in pseudorandom mode
        len_sel = 7; seed = 32'hFFFF_FF00; load_pin = 1; tick("R6");
        load_pin = 0; run(20, "R6");

        // R9: enable low holds the pattern
        bit_en = 0; run(10, "R9");
        // R10: load acts with enable low
        seed = 32'h0000_0055; prbs_mode = 0; load_reg = 1; tick("R10");
        run(3, "R10");
        load_reg = 0; bit_en = 1; run(8, "R10");

        // R5: held strobe and handover between sources
        seed = 32'h0000_00C3; load_reg = 1; tick("R5");
        run(12, "R5");
        load_pin = 1; run(4, "R5");
        load_reg = 0; run(4, "R5");
        load_pin = 0; run(3, "R5");
        seed = 32'h0000_0011; load_pin = 1; tick("R5");
        load_pin = 0; run(10, "R5");

        // R7: zero suppression on a 20-bit word with 19 zeros
        len_sel = 19; seed = 32'h1; zsup_en = 1; load_reg = 1; tick("R7");
        load_reg = 0;
        zeros = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (tdata === 1'b0) zeros++;
            check("R7", tdata, model_out());
            model_step();
            @(negedge clk);
        end
        check("R7 zeros per period", (zeros == 13), 1'b1);
        if (zeros != 13) $display("FAIL R7: zeros=%0d expected 13", zeros);
        run(25, "R7");

        // R8: inversion over a pseudorandom run
        zsup_en = 0; prbs_mode = 1; len_sel = 6; tap_sel = 5; seed = 32'h2A;
        load_reg = 1; tick("R8");
        load_reg = 0; tx_inv = 1; run(30, "R8");
        bit_en = 0; run(3, "R8");
        tx_inv = 0; run(3, "R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule